// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Unit

This block holds a small set-associative table of address translations. Software manages it through four registers: two descriptor words, an index register and a command register. Software loads the descriptor words with a virtual page tag and its attributes, then writes a command code. The unit looks the page up in its set, then stores, reads, places or removes entries. The result comes back in the index register or in the descriptor words.

Descriptor word 0 holds the page-aligned virtual address in bits [31:PAGE_BITS], a present bit at bit 9, a global bit at bit 8 and an 8-bit address-space ID in bits [7:0]. Descriptor word 1 is opaque translation data, stored and returned unchanged. The set of a page is selected by the lowest virtual page number bits, `pd0[PAGE_BITS +: log2(SETS)]`. An entry sits at linear index `set*WAYS + way`.

Command codes are written to bits [3:0] of register 3: 1 probe, 2 get-index, 3 write, 4 write without micro-TLB flush, 5 read, 6 insert, 7 delete, 8 micro-TLB invalidate. Register addresses are 0 for descriptor word 0, 1 for descriptor word 1, 2 for the index and 3 for the command. With the default parameters there are 8 sets of 4 ways and 13 page-offset bits.

Top module: `tlb_unit`

## Requirements
- R1: After reset, both descriptor registers and the index register read zero, `busy` is low, `utlbInval` is low and every entry is blank.
- R2: An entry matches descriptor word 0 when all of the following hold: its present bit is set, its virtual page bits [31:PAGE_BITS] are equal, and either its global bit is set or its ASID bits [7:0] are equal. The present and global bits of the key itself are not compared.
- R3: A probe that matches exactly one way writes `set*WAYS + way` to the index register, with bits [31:30] clear.
- R4: A probe that matches no way writes 0x8000_0000 (the error flag, bit 31) to the index register.
- R5: A probe that matches two or more ways of the set writes 0xC000_0000 to the index register. This duplicate code is distinct from the not-found code.
- R6: Get-index writes the index of the lowest-numbered non-present way of the key's set. If every way is present, it writes the way given by a per-set round-robin pointer and advances that pointer by one.
- R7: Write stores both descriptor words at the entry named by the low index bits and pulses `utlbInval`. Write-without-flush stores the same way but leaves `utlbInval` low.
- R8: Read loads both descriptor registers from the entry named by the low index bits.
- R9: Insert looks the key up itself. If one or more ways match, it overwrites the lowest matching way. Otherwise it places the entry as get-index would choose. In both cases it leaves the chosen index in the index register and pulses `utlbInval`.
- R10: Delete clears every way of the key's set that matches descriptor word 0 and leaves the other ways untouched. It pulses `utlbInval`.
- R11: An accepted command keeps `busy` high for exactly two cycles. Register writes while `busy` is high are ignored. A command code outside 1..8 is ignored and does not raise `busy`.
- R12: The invalidate command pulses `utlbInval` for one cycle. It changes neither the registers nor the entries.
- R13: Writing an all-zero descriptor pair makes a blank entry that no probe matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 word 0, 1 word 1, 2 index, 3 command |
| regWdata | input | 32 | Register write data |
| pd0Out | output | 32 | Descriptor word 0 register |
| pd1Out | output | 32 | Descriptor word 1 register |
| idxOut | output | 32 | Index register (bit 31 error, bit 30 duplicate) |
| busy | output | 1 | High while a command is running |
| utlbInval | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
Lookups are tried with keys that differ from a stored entry only in ASID, with a global entry probed under a foreign ASID, and with the same tag stored in two ways of one set. These cases separate the match rule from the three probe outcomes. Placement is tried on a set with free ways, on a full set probed twice in a row, and with insert on both a present and an absent tag. These cases tell first-free selection apart from round-robin selection and from overwrite-in-place. Register writes issued during a running command, and an unknown command code, show whether the busy interlock really holds the registers.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PRES_BIT = 9;
  localparam int GLB_BIT  = 8;
  localparam logic [31:0] ERR_MISS = 32'h8000_0000;
  localparam logic [31:0] ERR_DUP  = 32'hC000_0000;

  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_PROBE  = 4'd1,
    CMD_GETIDX = 4'd2,
    CMD_WRITE  = 4'd3,
    CMD_WRNI   = 4'd4,
    CMD_READ   = 4'd5,
    CMD_INSERT = 4'd6,
    CMD_DELETE = 4'd7,
    CMD_IVUTLB = 4'd8
  } cmd_e;

  typedef struct packed {
    logic lookup;
    logic probe;
    logic getIdx;
    logic write;
    logic read;
    logic insert;
    logic del;
  } strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [3:0] cmdCode,
  output logic       busy,
  output logic       utlbInval,
  output strobe_t    stb
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_EXEC} state_e;
  state_e state;
  cmd_e   cmdQ;
  logic   accept;
  logic   flushCmd;

  assign busy   = (state != S_IDLE);
  assign accept = regWe && (regAddr == 2'd3) && (state == S_IDLE) &&
                  (cmdCode >= 4'd1) && (cmdCode <= 4'd8);
  assign flushCmd = (cmdQ == CMD_WRITE) || (cmdQ == CMD_INSERT) ||
                    (cmdQ == CMD_DELETE) || (cmdQ == CMD_IVUTLB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cmdQ      <= CMD_NONE;
      utlbInval <= 1'b0;
    end else begin
      utlbInval <= (state == S_EXEC) && flushCmd;
      case (state)
        S_IDLE: if (accept) begin
          state <= S_LOOK;
          cmdQ  <= cmd_e'(cmdCode);
        end
        S_LOOK:  state <= S_EXEC;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.lookup = (state == S_LOOK);
    if (state == S_EXEC) begin
      stb.probe  = (cmdQ == CMD_PROBE);
      stb.getIdx = (cmdQ == CMD_GETIDX);
      stb.write  = (cmdQ == CMD_WRITE) || (cmdQ == CMD_WRNI);
      stb.read   = (cmdQ == CMD_READ);
      stb.insert = (cmdQ == CMD_INSERT);
      stb.del    = (cmdQ == CMD_DELETE);
    end
  end
endmodule

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int PAGE_BITS = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic        busy,
  input  strobe_t     stb,
  output logic [31:0] pd0Out,
  output logic [31:0] pd1Out,
  output logic [31:0] idxOut
);
  localparam int SETW    = $clog2(SETS);
  localparam int WAYW    = $clog2(WAYS);
  localparam int IDXW    = SETW + WAYW;
  localparam int ENTRIES = SETS * WAYS;

  logic [31:0]     pd0Reg, pd1Reg, idxReg;
  logic [31:0]     pd0Mem [ENTRIES];
  logic [31:0]     pd1Mem [ENTRIES];
  logic [WAYW-1:0] rrPtr  [SETS];

  logic [SETW-1:0] curSet, setQ;
  logic [WAYS-1:0] matchNow, hitQ;
  logic            freeNow, freeQ;
  logic [WAYW-1:0] freeWayNow, freeWayQ, hitWay, victimWay, insWay;
  logic [IDXW-1:0] idxField;
  int              hitCnt;
  logic            insUsesRr;

  function automatic logic entryHits(input logic [31:0] e, input logic [31:0] k);
    return e[PRES_BIT] && (e[31:PAGE_BITS] == k[31:PAGE_BITS]) &&
           (e[GLB_BIT] || (e[7:0] == k[7:0]));
  endfunction

  assign curSet   = pd0Reg[PAGE_BITS +: SETW];
  assign idxField = idxReg[IDXW-1:0];

  always_comb begin
    matchNow   = '0;
    freeNow    = 1'b0;
    freeWayNow = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      matchNow[w] = entryHits(pd0Mem[{curSet, WAYW'(w)}], pd0Reg);
      if (!pd0Mem[{curSet, WAYW'(w)}][PRES_BIT]) begin
        freeNow    = 1'b1;
        freeWayNow = WAYW'(w);
      end
    end
  end

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hitQ[w]) hitWay = WAYW'(w);
    hitCnt    = $countones(hitQ);
    victimWay = freeQ ? freeWayQ : rrPtr[setQ];
    insWay    = (hitCnt != 0) ? hitWay : victimWay;
    insUsesRr = (hitCnt == 0) && !freeQ;
  end

  // entry storage, lookup capture and replacement pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        pd0Mem[i] <= '0;
        pd1Mem[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
      hitQ     <= '0;
      freeQ    <= 1'b0;
      freeWayQ <= '0;
      setQ     <= '0;
    end else begin
      if (stb.lookup) begin
        hitQ     <= matchNow;
        freeQ    <= freeNow;
        freeWayQ <= freeWayNow;
        setQ     <= curSet;
      end
      if (stb.write) begin
        pd0Mem[idxField] <= pd0Reg;
        pd1Mem[idxField] <= pd1Reg;
      end
      if (stb.insert) begin
        pd0Mem[{setQ, insWay}] <= pd0Reg;
        pd1Mem[{setQ, insWay}] <= pd1Reg;
      end
      if (stb.del) begin
        for (int w = 0; w < WAYS; w++)
          if (hitQ[w]) begin
            pd0Mem[{setQ, WAYW'(w)}] <= '0;
            pd1Mem[{setQ, WAYW'(w)}] <= '0;
          end
      end
      if ((stb.getIdx && !freeQ) || (stb.insert && insUsesRr))
        rrPtr[setQ] <= rrPtr[setQ] + 1'b1;
    end
  end

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pd0Reg <= '0;
      pd1Reg <= '0;
      idxReg <= '0;
    end else begin
      if (regWe && !busy) begin
        case (regAddr)
          2'd0:    pd0Reg <= regWdata;
          2'd1:    pd1Reg <= regWdata;
          2'd2:    idxReg <= 32'(regWdata[IDXW-1:0]);
          default: ;
        endcase
      end
      if (stb.probe) begin
        if (hitCnt == 0)     idxReg <= ERR_MISS;
        else if (hitCnt > 1) idxReg <= ERR_DUP;
        else                 idxReg <= 32'({setQ, hitWay});
      end
      if (stb.getIdx) idxReg <= 32'({setQ, victimWay});
      if (stb.insert) idxReg <= 32'({setQ, insWay});
      if (stb.read) begin
        pd0Reg <= pd0Mem[idxField];
        pd1Reg <= pd1Mem[idxField];
      end
    end
  end

  assign pd0Out = pd0Reg;
  assign pd1Out = pd1Reg;
  assign idxOut = idxReg;
endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
  import tlb_pkg::*;
#(
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int PAGE_BITS = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] pd0Out,
  output logic [31:0] pd1Out,
  output logic [31:0] idxOut,
  output logic        busy,
  output logic        utlbInval
);
  strobe_t stb;

  tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .cmdCode(regWdata[3:0]), .busy(busy), .utlbInval(utlbInval), .stb(stb)
  );

  tlb_dpath #(.SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PAGE_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .busy(busy), .stb(stb),
    .pd0Out(pd0Out), .pd1Out(pd1Out), .idxOut(idxOut)
  );
endmodule

// File: rtl/tlb_unit_chk.sv
module tlb_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regAddr,
  input logic [31:0] regWdata,
  input logic [31:0] pd0Out,
  input logic [31:0] pd1Out,
  input logic [31:0] idxOut,
  input logic        busy,
  input logic        utlbInval
);
  p_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd3 && !busy && regWdata[3:0] >= 4'd1 && regWdata[3:0] <= 4'd8) |=> busy);

  p_bad_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(regWe && regAddr == 2'd3 && regWdata[3:0] >= 4'd1 && regWdata[3:0] <= 4'd8)) |=> !busy);

  p_busy_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);

  p_hold_regs_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> ($stable(pd0Out) && $stable(pd1Out) && $stable(idxOut)));

  p_inval_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    utlbInval |-> !busy);

  p_inval_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    utlbInval |=> !utlbInval);

  p_err_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    idxOut[31] |-> (idxOut[29:0] == 30'd0));
endmodule

bind tlb_unit tlb_unit_chk u_chk (.*);

// File: tb/sim_tlb_unit.sv
module sim_tlb_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] pd0Out, pd1Out, idxOut;
  logic        busy, utlbInval;
  int          nRun = 0;
  int          nFail = 0;
  logic        sawInval;
  bit          done = 0;

  always #5 clk = ~clk;

  tlb_unit u0 (.*);

  function automatic logic [31:0] mk(input int vpn, input int asid, input bit glb, input bit pres);
    return (32'(vpn) << 13) | (32'(pres) << 9) | (32'(glb) << 8) | 32'(asid[7:0]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic cmd(input int code);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'(code);
    @(negedge clk);
    regWe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sawInval = utlbInval;
  endtask

  task automatic tReset;
    chk("R1 pd0", pd0Out, 0);
    chk("R1 pd1", pd1Out, 0);
    chk("R1 idx", idxOut, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 inval", 32'(utlbInval), 0);
    wr(0, mk(5, 1, 0, 0)); cmd(1);
    chk("R1 blank probe", idxOut, 32'h8000_0000);
  endtask

  task automatic tWriteProbe;
    wr(2, 22); wr(0, mk(5, 1, 0, 1)); wr(1, 32'hABCD);
    cmd(3);
    chk("R7 write inval", 32'(sawInval), 1);
    wr(0, mk(5, 1, 0, 0)); cmd(1);
    chk("R3 probe hit", idxOut, 22);
    wr(0, mk(5, 2, 0, 0)); cmd(1);
    chk("R2 R4 asid mismatch miss", idxOut, 32'h8000_0000);
  endtask

  task automatic tGlobal;
    wr(0, mk(12, 0, 1, 1)); cmd(2);
    chk("R6 first free", idxOut, 16);
    wr(1, 32'h5555); cmd(4);
    chk("R7 writeNi no inval", 32'(sawInval), 0);
    wr(0, mk(12, 8'h33, 0, 0)); cmd(1);
    chk("R2 global any asid", idxOut, 16);
  endtask

  task automatic tRead;
    wr(2, 22); cmd(5);
    chk("R8 read pd0", pd0Out, mk(5, 1, 0, 1));
    chk("R8 read pd1", pd1Out, 32'hABCD);
  endtask

  task automatic tDupDelete;
    wr(2, 23); cmd(3);
    cmd(1);
    chk("R5 dup code", idxOut, 32'hC000_0000);
    wr(0, mk(5, 9, 0, 1)); wr(2, 21); cmd(3);
    wr(0, mk(5, 1, 0, 1)); cmd(7);
    chk("R10 delete inval", 32'(sawInval), 1);
    cmd(1);
    chk("R10 deleted miss", idxOut, 32'h8000_0000);
    wr(0, mk(5, 9, 0, 0)); cmd(1);
    chk("R10 other way kept", idxOut, 21);
  endtask

  task automatic tInsert;
    wr(0, mk(9, 3, 0, 1)); wr(1, 32'h11); cmd(6);
    chk("R9 insert free", idxOut, 4);
    chk("R9 insert inval", 32'(sawInval), 1);
    wr(1, 32'h22); cmd(6);
    chk("R9 insert overwrite", idxOut, 4);
    cmd(5);
    chk("R9 overwritten data", pd1Out, 32'h22);
    wr(0, mk(17, 3, 0, 1)); cmd(6);
    chk("R9 insert next free", idxOut, 5);
  endtask

  task automatic tRoundRobin;
    for (int i = 0; i < 4; i++) begin
      wr(0, mk(2 + 8 * i, 1, 0, 1)); cmd(6);
      chk("R9 fill set2", idxOut, 32'(8 + i));
    end
    wr(0, mk(34, 1, 0, 1)); cmd(2);
    chk("R6 rr first", idxOut, 8);
    cmd(2);
    chk("R6 rr advance", idxOut, 9);
    cmd(6);
    chk("R9 insert via rr", idxOut, 10);
  endtask

  task automatic tBusy;
    wr(0, mk(5, 9, 0, 0));
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'd1;
    @(negedge clk);
    chk("R11 busy high", 32'(busy), 1);
    regAddr = 2'd0; regWdata = 32'hDEAD_0000;
    @(negedge clk);
    chk("R11 busy second", 32'(busy), 1);
    regAddr = 2'd2; regWdata = 32'd3;
    @(negedge clk);
    regWe = 1'b0;
    chk("R11 busy done", 32'(busy), 0);
    chk("R11 pd0 ignored", pd0Out, mk(5, 9, 0, 0));
    chk("R11 idx ignored", idxOut, 21);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'hF;
    @(negedge clk);
    regWe = 1'b0;
    chk("R11 bad code idle", 32'(busy), 0);
  endtask

  task automatic tInval;
    cmd(8);
    chk("R12 pulse", 32'(sawInval), 1);
    chk("R12 idx kept", idxOut, 21);
    chk("R12 pd0 kept", pd0Out, mk(5, 9, 0, 0));
    @(negedge clk);
    chk("R12 pulse ended", 32'(utlbInval), 0);
  endtask

  task automatic tBlank;
    wr(2, 16); wr(0, 0); wr(1, 0); cmd(3);
    wr(0, mk(12, 0, 0, 0)); cmd(1);
    chk("R13 blank entry misses", idxOut, 32'h8000_0000);
    wr(0, 0); cmd(1);
    chk("R13 zero key misses", idxOut, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tWriteProbe;
    tGlobal;
    tRead;
    tDupDelete;
    tInsert;
    tRoundRobin;
    tBusy;
    tInval;
    tBlank;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule